// File: doc/BRIEF.md
# Host to Controller Register Transfer Bridge

This block lets a host CPU reach the 16-bit register port of a network controller through a byte-wide, memory-mapped window. The controller port has two destinations: an address port, which picks one of the controller's internal registers, and a data port, which moves the selected register's contents. The host does not drive the controller directly. It loads a transfer word, byte by byte, into a write holding register. It then sets the direction and destination in a control register and writes anything at all to a command location. That write starts one sequenced strobe/acknowledge cycle on the controller side.

While the transfer runs, a busy flag is visible in a status register. The status register sits at the same host offset as the control register: reads return status and writes update control. A read transfer leaves its result in a read holding register. That register shares host offsets with the write holding register but is a separate store, so a host read never returns the bytes the host just wrote. A control bit drives the controller's active-low reset. Holding that bit low also forces the bridge back to idle.

Host offsets for the default two byte lanes are fixed: 0 holds the low byte, 1 the high byte, 2 is status/control, and 3 is the command location.

Top module: `ctlr_regport_bridge`

## Requirements
- R1: After the synchronous reset, the control register is 0, so `ctl_rst_n` is 0. `ctl_stb` is 0, the read holding register reads 0 at offsets 0 and 1, and a status read returns 0x10 when `ctl_irq` is 0.
- R2: `ctl_rst_n` equals control bit 3 as written by the most recent host write to offset 2. It changes on the clock edge of that write.
- R3: A host write of any value to offset 3, while idle and with control bit 3 at 1, raises `ctl_strobe` on the next edge. That edge also fixes `ctl_rnw` to control bit 1 (1 = read), `ctl_sel_addr` to control bit 0 (1 = address port) and `ctl_wdata` to {byte at offset 1, byte at offset 0}. The strobe stays high until the edge that samples `ctl_ack`, and then falls.
- R4: Status bit 5 reads 1 from the command edge until one cycle after the acknowledge edge. With an acknowledge d cycles after the strobe rises, busy lasts d+2 cycles and the strobe lasts d+1 cycles.
- R5: On a read transfer, `ctl_rdata` is captured into the read holding register on the acknowledge edge. The host reads it back as the low byte at offset 0 and the high byte at offset 1.
- R6: Write transfers and host writes to offsets 0 and 1 leave the read holding register unchanged.
- R7: Status bit 4 reads the inverse of `ctl_irq`. All other status bits except bit 5 read 0, whatever the control register holds.
- R8: A command write that arrives while busy is ignored. No second transfer follows, and the outputs latched for the running transfer do not change.
- R9: While control bit 3 is 0, the bridge drops any transfer in progress. One cycle later the strobe and busy are 0, and command writes start nothing.
- R10: Host reads return data on the cycle after `host_re`, and a read of offset 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | 2 | Host register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |
| ctl_rst_n | output | 1 | Active-low controller reset |
| ctl_stb | output | 1 | Transfer strobe to controller |
| ctl_sel_addr | output | 1 | 1 = address port, 0 = data port |
| ctl_rnw | output | 1 | 1 = read from controller, 0 = write |
| ctl_wdata | output | 16 | Transfer word to controller |
| ctl_rdata | input | 16 | Word returned by controller |
| ctl_ack | input | 1 | Controller acknowledge |
| ctl_irq | input | 1 | Controller interrupt request, active high |

## Verification
The main sweep runs every combination of direction and destination, each against acknowledge latencies of 0 to 3 cycles. The transfer words include all-ones, all-zeros and computed mixed patterns. The latencies separate correct busy and strobe lengths from off-by-one sequencing. The four combinations show whether direction and destination are latched and decoded independently. A write followed by a read of the same controller register shows whether the write and read holding stores are truly separate. Further tests cover a command write during a long transfer, pulling the reset bit low in the middle of a transfer, and both interrupt levels.

// File: rtl/rpb_pkg.sv
package rpb_pkg;
  // transfer sequencer states
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_STRB = 2'd1,
    SQ_DONE = 2'd2
  } seq_state_e;

  // control bit positions (host write at control/status offset)
  localparam int CB_SEL = 0;  // 1 = address port
  localparam int CB_RNW = 1;  // 1 = read from controller
  localparam int CB_RUN = 3;  // 0 = controller held in reset

  // status bit positions (host read at control/status offset)
  localparam int SB_IRQN = 4; // 0 = interrupt pending
  localparam int SB_BUSY = 5; // 1 = transfer in progress
endpackage

// File: rtl/rpb_host_regs.sv
module rpb_host_regs
  import rpb_pkg::*;
#(
  parameter int HOST_W = 8,
  parameter int LANES  = 2,
  localparam int XFER_W = LANES * HOST_W,
  localparam int ADDR_W = $clog2(LANES + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  input  logic              busy,
  input  logic              irq,
  input  logic [XFER_W-1:0] rd_hold,
  output logic [XFER_W-1:0] wr_hold,
  output logic              run,
  output logic              rnw_sel,
  output logic              port_sel,
  output logic              cmd_req
);
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(LANES);
  localparam logic [ADDR_W-1:0] CMD_OFS  = ADDR_W'(LANES + 1);

  // write holding register, one byte lane per host offset
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        wr_hold[g*HOST_W +: HOST_W] <= '0;
      end else if (host_we && host_addr == ADDR_W'(g)) begin
        wr_hold[g*HOST_W +: HOST_W] <= host_wdata;
      end
    end
  end

  // control register: only the three defined bits are stored
  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      rnw_sel  <= 1'b0;
      port_sel <= 1'b0;
    end else if (host_we && host_addr == CTRL_OFS) begin
      run      <= host_wdata[CB_RUN];
      rnw_sel  <= host_wdata[CB_RNW];
      port_sel <= host_wdata[CB_SEL];
    end
  end

  assign cmd_req = host_we && (host_addr == CMD_OFS);

  // read side: status word and read holding lanes
  logic [HOST_W-1:0] status_w;
  logic [HOST_W-1:0] rd_next;

  always_comb begin
    status_w          = '0;
    status_w[SB_BUSY] = busy;
    status_w[SB_IRQN] = ~irq;
  end

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < LANES; k++) begin
      if (host_addr == ADDR_W'(k)) rd_next = rd_hold[k*HOST_W +: HOST_W];
    end
    if (host_addr == CTRL_OFS) rd_next = status_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_re) begin
      host_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/rpb_xfer_seq.sv
module rpb_xfer_seq
  import rpb_pkg::*;
#(
  parameter int XFER_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              start,
  input  logic              rnw_in,
  input  logic              sel_in,
  input  logic [XFER_W-1:0] wdata_in,
  input  logic              ack,
  input  logic [XFER_W-1:0] rdata,
  output logic              stb,
  output logic              busy,
  output logic              rnw,
  output logic              sel,
  output logic [XFER_W-1:0] wdata,
  output logic [XFER_W-1:0] rd_hold
);
  seq_state_e state;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      state <= SQ_IDLE;
    end else begin
      unique case (state)
        SQ_IDLE: if (start) state <= SQ_STRB;
        SQ_STRB: if (ack)   state <= SQ_DONE;
        SQ_DONE:            state <= SQ_IDLE;
        default:            state <= SQ_IDLE;
      endcase
    end
  end

  // transfer attributes are frozen at the start edge
  always_ff @(posedge clk) begin
    if (rst) begin
      rnw   <= 1'b0;
      sel   <= 1'b0;
      wdata <= '0;
    end else if (run && state == SQ_IDLE && start) begin
      rnw   <= rnw_in;
      sel   <= sel_in;
      wdata <= wdata_in;
    end
  end

  // read holding register, loaded only by an acknowledged read
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hold <= '0;
    end else if (run && state == SQ_STRB && ack && rnw) begin
      rd_hold <= rdata;
    end
  end

  assign stb  = (state == SQ_STRB);
  assign busy = (state != SQ_IDLE);
endmodule

// File: rtl/ctlr_regport_bridge.sv
module ctlr_regport_bridge
  import rpb_pkg::*;
#(
  parameter int HOST_W = 8,
  parameter int LANES  = 2,
  localparam int XFER_W = LANES * HOST_W,
  localparam int ADDR_W = $clog2(LANES + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic              ctl_rst_n,
  output logic              ctl_stb,
  output logic              ctl_sel_addr,
  output logic              ctl_rnw,
  output logic [XFER_W-1:0] ctl_wdata,
  input  logic [XFER_W-1:0] ctl_rdata,
  input  logic              ctl_ack,
  input  logic              ctl_irq
);
  logic              busy;
  logic              run;
  logic              rnw_sel;
  logic              port_sel;
  logic              cmd_req;
  logic [XFER_W-1:0] wr_hold;
  logic [XFER_W-1:0] rd_hold;

  rpb_host_regs #(.HOST_W(HOST_W), .LANES(LANES)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .host_we    (host_we),
    .host_re    (host_re),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .busy       (busy),
    .irq        (ctl_irq),
    .rd_hold    (rd_hold),
    .wr_hold    (wr_hold),
    .run        (run),
    .rnw_sel    (rnw_sel),
    .port_sel   (port_sel),
    .cmd_req    (cmd_req)
  );

  rpb_xfer_seq #(.XFER_W(XFER_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .start    (cmd_req),
    .rnw_in   (rnw_sel),
    .sel_in   (port_sel),
    .wdata_in (wr_hold),
    .ack      (ctl_ack),
    .rdata    (ctl_rdata),
    .stb      (ctl_stb),
    .busy     (busy),
    .rnw      (ctl_rnw),
    .sel      (ctl_sel_addr),
    .wdata    (ctl_wdata),
    .rd_hold  (rd_hold)
  );

  assign ctl_rst_n = run;
endmodule

// File: rtl/rpb_checker.sv
module rpb_checker #(
  parameter int HOST_W = 8,
  parameter int LANES  = 2,
  localparam int XFER_W = LANES * HOST_W,
  localparam int ADDR_W = $clog2(LANES + 2)
) (
  input logic              clk,
  input logic              rst,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_addr,
  input logic              ctl_rst_n,
  input logic              ctl_stb,
  input logic              ctl_ack,
  input logic              ctl_rnw,
  input logic              ctl_sel_addr,
  input logic [XFER_W-1:0] ctl_wdata,
  input logic [XFER_W-1:0] ctl_rdata,
  input logic              busy,
  input logic [XFER_W-1:0] rd_hold
);
  logic cmd_wr;
  assign cmd_wr = host_we && (host_addr == ADDR_W'(LANES + 1));

  // R3: an accepted command raises the strobe on the next edge
  p_cmd_starts_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !busy && ctl_rst_n) |=> (ctl_stb && busy));

  // R3: the acknowledge ends the strobe
  p_ack_ends_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    (ctl_stb && ctl_ack) |=> !ctl_stb);

  // R4: the strobe only appears while busy
  p_strobe_in_busy_r4: assert property (@(posedge clk) disable iff (rst)
    ctl_stb |-> busy);

  // R4: busy ends one cycle after the acknowledge
  p_busy_tail_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl_stb && ctl_ack && ctl_rst_n) |=> (busy ##1 !busy));

  // R5: an acknowledged read loads the read holding register
  p_rd_capture_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl_stb && ctl_ack && ctl_rnw && ctl_rst_n) |=> (rd_hold == $past(ctl_rdata)));

  // R6: nothing else alters the read holding register
  p_rd_hold_kept_r6: assert property (@(posedge clk) disable iff (rst)
    !(ctl_stb && ctl_ack && ctl_rnw) |=> $stable(rd_hold));

  // R8: a command while busy leaves the running transfer untouched
  p_busy_cmd_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && busy) |=> ($stable(ctl_wdata) && $stable(ctl_rnw) && $stable(ctl_sel_addr)));

  // R9: controller reset forces the bridge idle
  p_reset_idles_r9: assert property (@(posedge clk) disable iff (rst)
    !ctl_rst_n |=> (!ctl_stb && !busy));
endmodule

bind ctlr_regport_bridge rpb_checker #(.HOST_W(HOST_W), .LANES(LANES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .host_we      (host_we),
  .host_addr    (host_addr),
  .ctl_rst_n    (ctl_rst_n),
  .ctl_stb      (ctl_stb),
  .ctl_ack      (ctl_ack),
  .ctl_rnw      (ctl_rnw),
  .ctl_sel_addr (ctl_sel_addr),
  .ctl_wdata    (ctl_wdata),
  .ctl_rdata    (ctl_rdata),
  .busy         (busy),
  .rd_hold      (rd_hold)
);

// File: tb/sim_ctlr_regport_bridge.sv
module sim_ctlr_regport_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic        host_re = 1'b0;
  logic [1:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        ctl_rst_n;
  logic        ctl_stb;
  logic        ctl_sel_addr;
  logic        ctl_rnw;
  logic [15:0] ctl_wdata;
  logic [15:0] ctl_rdata = 16'hDEAD;
  logic        ctl_ack = 1'b0;
  logic        ctl_irq = 1'b0;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ctlr_regport_bridge u0 (
    .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ctl_rst_n(ctl_rst_n), .ctl_stb(ctl_stb), .ctl_sel_addr(ctl_sel_addr),
    .ctl_rnw(ctl_rnw), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .ctl_ack(ctl_ack), .ctl_irq(ctl_irq)
  );

  // controller model: address register plus four data registers
  int          m_delay = 0;
  int          m_cnt = 0;
  int          m_run = 0;
  int          m_last_stb = 0;
  int          m_xfers = 0;
  logic [15:0] m_addr = '0;
  logic [15:0] m_regs [4];
  logic        seen_rnw = 1'b0;
  logic        seen_sel = 1'b0;
  logic [15:0] seen_wdata = '0;

  always @(negedge clk) begin
    if (!ctl_stb) begin
      ctl_ack = 1'b0;
      m_cnt   = 0;
      m_run   = 0;
    end else begin
      m_run++;
      if (!ctl_ack && m_cnt == m_delay) begin
        ctl_ack    = 1'b1;
        m_last_stb = m_run;
        m_xfers++;
        seen_rnw   = ctl_rnw;
        seen_sel   = ctl_sel_addr;
        seen_wdata = ctl_wdata;
        if (ctl_rnw) ctl_rdata = ctl_sel_addr ? m_addr : m_regs[m_addr[1:0]];
        else if (ctl_sel_addr) m_addr = ctl_wdata;
        else m_regs[m_addr[1:0]] = ctl_wdata;
      end else if (!ctl_ack) begin
        m_cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_re = 1'b1; host_addr = a;
    @(negedge clk);
    host_re = 1'b0;
    d = host_rdata;
  endtask

  task automatic read_hold(output logic [15:0] v);
    logic [7:0] lo, hi;
    host_read(2'd0, lo);
    host_read(2'd1, hi);
    v = {hi, lo};
  endtask

  // load operands, issue command, poll status every cycle; returns busy reads
  task automatic do_xfer(input logic sel, input logic rnw, input logic [15:0] data,
                         output int busy_n);
    host_write(2'd0, data[7:0]);
    host_write(2'd1, data[15:8]);
    host_write(2'd2, {4'b0000, 1'b1, 1'b0, rnw, sel});
    @(negedge clk);
    host_we = 1'b1; host_addr = 2'd3; host_wdata = 8'hA7;
    @(negedge clk);
    host_we = 1'b0; host_re = 1'b1; host_addr = 2'd2;
    busy_n = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (host_rdata[5]) busy_n++;
      else break;
    end
    host_re = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    logic [15:0] exp_rd;
    logic [15:0] val;
    int          bn;
    int          x0;
    for (int i = 0; i < 4; i++) m_regs[i] = '0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check(ctl_rst_n == 1'b0, "R1 rst_n", ctl_rst_n, 0);
    check(ctl_stb == 1'b0, "R1 stb", ctl_stb, 0);
    host_read(2'd2, b);
    check(b == 8'h10, "R1 status", b, 8'h10);
    read_hold(v);
    check(v == 16'h0000, "R1 read hold", v, 0);

    // R9: command while held in reset starts nothing
    x0 = m_xfers;
    host_write(2'd3, 8'h00);
    check(ctl_stb == 1'b0, "R9 cmd in reset", ctl_stb, 0);

    // R2: control bit 3 drives controller reset
    host_write(2'd2, 8'h08);
    check(ctl_rst_n == 1'b1, "R2 rst_n high", ctl_rst_n, 1);
    host_write(2'd2, 8'h07);
    check(ctl_rst_n == 1'b0, "R2 rst_n low", ctl_rst_n, 0);
    host_write(2'd2, 8'h08);
    check(m_xfers == x0, "R9 no transfer", m_xfers, x0);

    // R7: interrupt bit inverted, other bits clear regardless of control
    host_write(2'd2, 8'h0B);
    ctl_irq = 1'b1;
    host_read(2'd2, b);
    check(b == 8'h00, "R7 irq pending", b, 0);
    ctl_irq = 1'b0;
    host_read(2'd2, b);
    check(b == 8'h10, "R7 irq clear", b, 8'h10);

    // R10: command offset reads zero
    host_read(2'd3, b);
    check(b == 8'h00, "R10 cmd reads 0", b, 0);

    // main sweep: latency x register x direction x destination
    exp_rd = 16'h0000;
    for (int d = 0; d < 4; d++) begin
      m_delay = d;
      for (int idx = 0; idx < 4; idx++) begin
        if (idx == 0) val = 16'hFFFF;
        else if (idx == 3) val = 16'h0000;
        else val = 16'((idx + 1) * 16'h3A5D + d * 16'h0F0F);

        // address port write
        x0 = m_xfers;
        do_xfer(1'b1, 1'b0, 16'(idx), bn);
        check(m_xfers == x0 + 1, "R3 one transfer", m_xfers, x0 + 1);
        check(seen_sel == 1'b1 && seen_rnw == 1'b0, "R3 addr write attrs",
              {seen_sel, seen_rnw}, 2'b10);
        check(seen_wdata == 16'(idx), "R3 addr write data", seen_wdata, idx);
        check(bn == d + 2, "R4 busy length", bn, d + 2);
        check(m_last_stb == d + 1, "R4 strobe length", m_last_stb, d + 1);

        // data port write
        do_xfer(1'b0, 1'b0, val, bn);
        check(seen_sel == 1'b0 && seen_rnw == 1'b0, "R3 data write attrs",
              {seen_sel, seen_rnw}, 2'b00);
        check(seen_wdata == val, "R3 data write data", seen_wdata, val);
        check(bn == d + 2, "R4 busy length", bn, d + 2);
        read_hold(v);
        check(v == exp_rd, "R6 read hold kept", v, exp_rd);

        // data port read
        do_xfer(1'b0, 1'b1, ~val, bn);
        check(seen_sel == 1'b0 && seen_rnw == 1'b1, "R3 data read attrs",
              {seen_sel, seen_rnw}, 2'b01);
        read_hold(v);
        exp_rd = val;
        check(v == exp_rd, "R5 data read", v, exp_rd);

        // address port read
        do_xfer(1'b1, 1'b1, 16'h5555, bn);
        check(seen_sel == 1'b1 && seen_rnw == 1'b1, "R3 addr read attrs",
              {seen_sel, seen_rnw}, 2'b11);
        check(m_last_stb == d + 1, "R4 strobe length", m_last_stb, d + 1);
        read_hold(v);
        exp_rd = 16'(idx);
        check(v == exp_rd, "R5 addr read", v, exp_rd);
      end
    end

    // R6: host writes to holding offsets do not show on the read side
    host_write(2'd0, 8'hC3);
    host_write(2'd1, 8'h3C);
    read_hold(v);
    check(v == exp_rd, "R6 host write not read back", v, exp_rd);

    // R8: command during a running transfer is ignored
    m_delay = 8;
    host_write(2'd0, 8'h34);
    host_write(2'd1, 8'h12);
    host_write(2'd2, 8'h08);
    x0 = m_xfers;
    host_write(2'd3, 8'h01);
    host_write(2'd0, 8'h99);
    host_write(2'd3, 8'hFF);
    check(ctl_wdata == 16'h1234, "R8 data frozen", ctl_wdata, 16'h1234);
    repeat (20) @(negedge clk);
    check(m_xfers == x0 + 1, "R8 single transfer", m_xfers, x0 + 1);
    check(seen_wdata == 16'h1234, "R8 first data kept", seen_wdata, 16'h1234);
    check(ctl_stb == 1'b0, "R8 no second strobe", ctl_stb, 0);

    // R9: reset bit low aborts a transfer in progress
    m_delay = 1000;
    x0 = m_xfers;
    host_write(2'd2, 8'h0A);
    host_write(2'd3, 8'h00);
    check(ctl_stb == 1'b1, "R3 strobe raised", ctl_stb, 1);
    host_write(2'd2, 8'h02);
    @(negedge clk);
    check(ctl_stb == 1'b0, "R9 strobe dropped", ctl_stb, 0);
    check(ctl_rst_n == 1'b0, "R9 rst_n low", ctl_rst_n, 0);
    host_read(2'd2, b);
    check(b == 8'h10, "R9 busy cleared", b, 8'h10);
    read_hold(v);
    check(v == exp_rd, "R9 read hold untouched", v, exp_rd);
    check(m_xfers == x0, "R9 no ack taken", m_xfers, x0);
    host_write(2'd2, 8'h08);
    host_read(2'd2, b);
    check(b == 8'h10, "R9 idle after release", b, 8'h10);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule